// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Port

This block is a byte-wide SPI port for a host CPU. A role bit in its control register chooses between bus master and bus slave. The same 8-bit shift register, edge counter and pin logic serve both roles. As master, the block generates SCK from the system clock through a four-way prescaler, drives MOSI and samples MISO. As slave, it synchronises the incoming SCK, MOSI and active-low select into the system clock domain. It shifts only while selected, and drives MISO only while selected.

The host sees three byte registers. Control is at address 0. Status is at address 1. Data is at address 2: writing it loads the shift register, and reading it returns a receive buffer. The buffer is refreshed only when a byte completes, so the previous byte can be read while the next one shifts. Completion sets a done flag, which can raise an interrupt. A data write during a transfer sets a collision flag and is discarded. Both flags are cleared by writing a 1 to them.

Top module: `spi_dualrole`

## Requirements
- R1: After reset, the control, status and data registers read 0 and irq is 0. While the enable bit (control bit 0) is 0, sck_oe, mosi_oe and miso_oe are all 0.
- R2: The role bit is control bit 1 (1 = master). With enable=1 and role=master, sck_oe=1, mosi_oe=1 and miso_oe=0. While no transfer runs, sck_o equals the polarity bit (control bit 2).
- R3: The rate field is control bits 7:6, with 00/01/10/11 giving system clock divided by 4/16/64/128. In master mode, the first SCK edge comes half a divided period after the data write, that is div/2 clock cycles after the writing edge. Every further SCK edge follows the previous one by div/2 cycles.
- R4: The master transfer is full duplex. After the 16th SCK edge, the data register reads the 8 bits that were sampled on miso_i.
- R5: The phase bit is control bit 3. With phase 0, data is sampled on the edge leaving the idle level. With phase 1, data is sampled on the edge returning to it. The order bit is control bit 4: with 0 the MSB goes first, with 1 the LSB goes first. The bits on MOSI at the sampling edges form the written byte, in that order.
- R6: In slave mode, miso_oe=1 only while ss_n_i is low, and sck_oe=mosi_oe=0. The byte shifted in on mosi_i ends up in the data register. The byte written to the data register leaves on miso_o.
- R7: In slave mode with ss_n_i high, SCK transitions neither advance the transfer nor set any flag.
- R8: Status bit 0 (done) is set at the end of each byte, together with the update of the receive buffer. The receive buffer keeps its value while the next byte shifts.
- R9: irq = done AND the interrupt-enable bit (control bit 5).
- R10: A data write while status bit 2 (busy) is 1 sets status bit 1 (collision). It changes neither the byte on the wire nor the byte received.
- R11: Writing 1 to status bit 0 or bit 1 clears that flag, and clearing done drops irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from the pad (slave role) |
| sck_o | output | 1 | Serial clock to the pad (master role) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | MOSI from the pad (slave role) |
| mosi_o | output | 1 | MOSI to the pad (master role) |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO from the pad (master role) |
| miso_o | output | 1 | MISO to the pad (slave role) |
| miso_oe | output | 1 | MISO output enable |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The hardest case to reach from the ports is a write collision. The second data write has to land strictly between the start of a master transfer and its last SCK edge. The stimulus times this from the first SCK edge it observes, then waits three half periods before writing the complement of the byte. A monitor rebuilds the byte from MOSI at the sampling edges, and MISO is looped back, so any corruption shows up both on the wire and in the received byte. Slave traffic is produced by the bench acting as master, including SCK toggling while deselected, to show that the edge counter stays at rest.

// File: rtl/spi_dr_pkg.sv
package spi_dr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    RATE_DIV4   = 2'd0,
    RATE_DIV16  = 2'd1,
    RATE_DIV64  = 2'd2,
    RATE_DIV128 = 2'd3
  } rate_e;

  typedef struct packed {
    logic [1:0] rate;
    logic       irq_en;
    logic       lsb_first;
    logic       cpha;
    logic       cpol;
    logic       master;
    logic       enable;
  } ctrl_t;

  // System clock cycles per SCK half period.
  function automatic int unsigned half_period(input logic [1:0] rate);
    case (rate_e'(rate))
      RATE_DIV4:  half_period = 2;
      RATE_DIV16: half_period = 8;
      RATE_DIV64: half_period = 32;
      default:    half_period = 64;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] sr,
                                                 input logic b, input logic lsb);
    shift_in = lsb ? {b, sr[BYTE_W-1:1]} : {sr[BYTE_W-2:0], b};
  endfunction

  function automatic logic out_bit(input logic [BYTE_W-1:0] sr, input logic lsb);
    out_bit = lsb ? sr[0] : sr[BYTE_W-1];
  endfunction
endpackage

// File: rtl/spi_dr_sync.sv
module spi_dr_sync #(
  parameter int             N       = 3,
  parameter int             STAGES  = 2,
  parameter logic [N-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= pipe[g-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_dr_prescaler.sv
module spi_dr_prescaler import spi_dr_pkg::*; #(
  parameter int MAX_HALF = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam int CNT_W = $clog2(MAX_HALF);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(half_period(rate) - 1);
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);  // R3
endmodule

// File: rtl/spi_dr_engine.sv
module spi_dr_engine import spi_dr_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              strobe,
  input  logic              cpha,
  input  logic              lsb,
  input  logic              din,
  output logic              dout,
  output logic              half,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rx_next
);
  localparam int EDGES = 2 * BYTE_W;
  localparam int CW    = $clog2(EDGES);

  logic [BYTE_W-1:0] sr;
  logic              latch;
  logic [CW-1:0]     cnt;
  logic              lead;
  logic              last;

  assign lead    = ~cnt[0];
  assign last    = (cnt == CW'(EDGES - 1));
  assign rx_next = shift_in(sr, cpha ? din : latch, lsb);
  assign dout    = out_bit(sr, lsb);
  assign half    = cnt[0];
  assign busy    = (cnt != '0);
  assign done    = strobe && last && !clr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (strobe) cnt <= last ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '0;
      latch <= 1'b0;
    end else if (load) begin
      sr    <= load_data;
      latch <= 1'b0;
    end else if (strobe && !clr) begin
      if (!cpha) begin
        if (lead) latch <= din;
        else      sr    <= shift_in(sr, latch, lsb);
      end else begin
        if (lead) begin
          if (cnt != '0) sr <= shift_in(sr, latch, lsb);
        end else begin
          latch <= din;
          if (last) sr <= rx_next;
        end
      end
    end
  end

  AST_BYTE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);  // R8
  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);  // R10
endmodule

// File: rtl/spi_dualrole.sv
module spi_dualrole import spi_dr_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       mosi_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       ss_n_i
);
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  ctrl_t             ctrl;
  logic              done_flag, wcol_flag, m_busy;
  logic [BYTE_W-1:0] rx_buf;

  logic sck_s, ss_s, mosi_s, sck_q;
  logic is_master, is_slave, slave_sel;
  logic wr_ctrl, wr_stat, wr_data, wcol_evt, load, start;
  logic tick, slave_edge, strobe, eng_clr, eng_din;
  logic eng_dout, eng_half, eng_busy, eng_done, busy_all;
  logic [BYTE_W-1:0] eng_rx;

  spi_dr_sync #(.N(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sck_i, ss_n_i, mosi_i}), .q({sck_s, ss_s, mosi_s}));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;

  assign is_master  = ctrl.enable &  ctrl.master;
  assign is_slave   = ctrl.enable & ~ctrl.master;
  assign slave_sel  = is_slave & ~ss_s;
  assign busy_all   = m_busy | eng_busy;

  assign wr_ctrl    = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_stat    = reg_wr && (reg_addr == ADDR_STAT);
  assign wr_data    = reg_wr && (reg_addr == ADDR_DATA);
  assign wcol_evt   = wr_data && ctrl.enable && busy_all;
  assign load       = wr_data && ctrl.enable && !busy_all;
  assign start      = load && is_master;

  spi_dr_prescaler #(.MAX_HALF(64)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(m_busy), .rate(ctrl.rate), .tick(tick));

  assign slave_edge = slave_sel & (sck_s ^ sck_q);
  assign strobe     = is_master ? tick : slave_edge;
  assign eng_clr    = ~ctrl.enable | (~ctrl.master & ss_s);
  assign eng_din    = is_master ? miso_i : mosi_s;

  spi_dr_engine u_eng (
    .clk(clk), .rst_n(rst_n), .clr(eng_clr), .load(load), .load_data(reg_wdata),
    .strobe(strobe), .cpha(ctrl.cpha), .lsb(ctrl.lsb_first), .din(eng_din),
    .dout(eng_dout), .half(eng_half), .busy(eng_busy), .done(eng_done),
    .rx_next(eng_rx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      m_busy    <= 1'b0;
      done_flag <= 1'b0;
      wcol_flag <= 1'b0;
      rx_buf    <= '0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(reg_wdata);

      if (!is_master)    m_busy <= 1'b0;
      else if (start)    m_busy <= 1'b1;
      else if (eng_done) m_busy <= 1'b0;

      if (eng_done)                     done_flag <= 1'b1;
      else if (wr_stat && reg_wdata[0]) done_flag <= 1'b0;

      if (wcol_evt)                     wcol_flag <= 1'b1;
      else if (wr_stat && reg_wdata[1]) wcol_flag <= 1'b0;

      if (eng_done) rx_buf <= eng_rx;
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = ctrl;
      ADDR_STAT: reg_rdata = {5'b0, busy_all, wcol_flag, done_flag};
      ADDR_DATA: reg_rdata = rx_buf;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq     = done_flag & ctrl.irq_en;
  assign sck_o   = ctrl.cpol ^ eng_half;
  assign sck_oe  = is_master;
  assign mosi_o  = eng_dout;
  assign mosi_oe = is_master;
  assign miso_o  = eng_dout;
  assign miso_oe = slave_sel;

  AST_OFF_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.enable |-> !(sck_oe || mosi_oe || miso_oe));  // R1
  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && !busy_all) |-> (sck_o == ctrl.cpol));  // R2
  AST_ROLE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> (!mosi_oe && !sck_oe));  // R6
  AST_DESELECT_RESTS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_slave && ss_s) |=> !eng_busy);  // R7
  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> done_flag);  // R8
  AST_WCOL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wcol_evt |=> wcol_flag);  // R10
  AST_DONE_CLEAR_BY_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_flag) |-> $past(wr_stat && reg_wdata[0]));  // R11
endmodule

// File: tb/spi_dualrole_tb.sv
module spi_dualrole_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;
  logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1, inv = 1'b0;
  logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_i, miso_o, miso_oe;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  assign miso_i = mosi_o ^ inv;  // loopback for master-mode checks

  spi_dualrole u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i));

  // Wire monitor: rebuilds the MOSI byte and measures SCK edge spacing.
  int         cyc = 0, mon_epoch = 0, seen_epoch = 0;
  int         mon_n = 0, last_edge = -1, gap_err = 0, m_half = 2;
  logic [7:0] mon_bits = '0;
  logic       sck_prev = 1'b0, mosi_prev = 1'b0;
  logic       m_cpol = 1'b0, m_cpha = 1'b0, m_lsb = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (seen_epoch != mon_epoch) begin
      seen_epoch = mon_epoch; mon_n = 0; mon_bits = '0; last_edge = -1; gap_err = 0;
    end else if (sck_oe && sck_o !== sck_prev) begin
      if (last_edge >= 0 && (cyc - last_edge) != m_half) gap_err++;
      last_edge = cyc;
      if (((sck_o != m_cpol) == !m_cpha) && mon_n < 8) begin
        if (m_lsb) mon_bits[mon_n] = mosi_prev;
        else       mon_bits[7-mon_n] = mosi_prev;
        mon_n++;
      end
    end
    sck_prev  = sck_o;
    mosi_prev = mosi_o;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_half(input logic [1:0] rate);
    int div;
    div = (rate == 2'd3) ? 128 : (4 << (2 * rate));
    return div / 2;
  endfunction

  function automatic logic [7:0] mk_ctrl(input logic [1:0] rate, input logic ie,
      input logic lsb, input logic cpha, input logic cpol, input logic mst, input logic en);
    return {rate, ie, lsb, cpha, cpol, mst, en};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic master_xfer(input logic [7:0] tx, input logic [1:0] rate,
      input logic cpol, input logic cpha, input logic lsb, input logic ie,
      input logic inv_in, input bit collide);
    logic [7:0] v;
    int n, lim, h;
    h = exp_half(rate);
    inv = inv_in; m_cpol = cpol; m_cpha = cpha; m_lsb = lsb; m_half = h;
    wr(2'd0, mk_ctrl(rate, ie, lsb, cpha, cpol, 1'b1, 1'b1));
    mon_epoch++;
    chk("R2 sck idle level", sck_o, cpol);
    chk("R2 master pin enables", {sck_oe, mosi_oe, miso_oe}, 3'b110);
    wr(2'd2, tx);
    n = 0;
    do begin @(negedge clk); n++; end while (sck_o == cpol && n < 200);
    chk("R3 first edge delay", n, h);
    if (collide) begin
      repeat (3 * h) @(negedge clk);
      rd(2'd1, v); chk("R10 busy mid byte", v[2], 1'b1);
      wr(2'd2, ~tx);
      rd(2'd1, v); chk("R10 collision flag", v[1], 1'b1);
    end
    lim = 0;
    do begin @(negedge clk); rd(2'd1, v); lim++; end while (!v[0] && lim < 20 * h + 40);
    chk("R8 done flag", v[0], 1'b1);
    rd(2'd2, v);
    chk(collide ? "R10 rx intact" : "R4 rx byte", v, tx ^ {8{inv_in}});
    chk(collide ? "R10 wire intact" : "R5 mosi stream", mon_bits, tx);
    chk("R5 sampling edge count", mon_n, 8);
    chk("R3 half period spacing", gap_err, 0);
    chk("R9 irq follows enable", irq, ie);
    wr(2'd1, 8'h03);
    rd(2'd1, v);
    chk("R11 flags cleared", v[1:0], 2'b00);
    chk("R11 irq dropped", irq, 1'b0);
  endtask

  task automatic slave_xfer(input logic [7:0] tx, input logic [7:0] rxin,
      input logic cpol, input logic cpha, input logic lsb, input bit noise);
    logic [7:0] v, got;
    logic b;
    sck_i = cpol; ss_n_i = 1'b1; mosi_i = 1'b0;
    wr(2'd0, mk_ctrl(2'd0, 1'b1, lsb, cpha, cpol, 1'b0, 1'b1));
    wr(2'd2, tx);
    repeat (4) @(negedge clk);
    chk("R6 miso released while deselected", miso_oe, 1'b0);
    if (noise) begin
      for (int k = 0; k < 6; k++) begin
        sck_i = ~sck_i; mosi_i = k[0];
        repeat (5) @(negedge clk);
      end
      rd(2'd1, v);
      chk("R7 no progress while deselected", v[2:0], 3'b000);
      chk("R7 miso quiet while deselected", miso_oe, 1'b0);
    end
    ss_n_i = 1'b0;
    repeat (6) @(negedge clk);
    chk("R6 slave pin enables", {miso_oe, sck_oe, mosi_oe}, 3'b100);
    got = '0;
    for (int i = 0; i < 8; i++) begin
      b = lsb ? rxin[i] : rxin[7-i];
      if (!cpha) begin
        mosi_i = b;
        repeat (6) @(negedge clk);
        if (lsb) got[i] = miso_o; else got[7-i] = miso_o;
        sck_i = ~cpol;
        repeat (6) @(negedge clk);
        sck_i = cpol;
      end else begin
        sck_i = ~cpol; mosi_i = b;
        repeat (6) @(negedge clk);
        if (lsb) got[i] = miso_o; else got[7-i] = miso_o;
        sck_i = cpol;
      end
      repeat (6) @(negedge clk);
    end
    rd(2'd1, v); chk("R8 slave done flag", v[0], 1'b1);
    rd(2'd2, v); chk("R6 slave received byte", v, rxin);
    chk("R6 slave sent byte", got, tx);
    chk("R9 slave irq", irq, 1'b1);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 miso released after deselect", miso_oe, 1'b0);
    wr(2'd1, 8'h03);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R8 act=%0d exp=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, a;
    int unsigned seed;
    seed = $urandom(32'h1D5E_0C2A);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk("R1 control reset", v, 8'h00);
    rd(2'd1, v); chk("R1 status reset", v, 8'h00);
    rd(2'd2, v); chk("R1 data reset", v, 8'h00);
    chk("R1 pins released at reset", {sck_oe, mosi_oe, miso_oe, irq}, 4'b0000);

    // Directed master corners
    master_xfer(8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    master_xfer(8'hFF, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    master_xfer(8'h80, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    master_xfer(8'h01, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    master_xfer(8'hA5, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    master_xfer(8'h3C, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);

    // Receive buffer holds the previous byte while the next one shifts (R8)
    master_xfer(8'h5A, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    wr(2'd2, 8'hC3);
    repeat (20) @(negedge clk);
    rd(2'd2, v); chk("R8 read buffer held", v, 8'h5A);
    repeat (300) @(negedge clk);
    rd(2'd2, v); chk("R8 read buffer updated", v, 8'hC3);
    wr(2'd1, 8'h03);

    // Disable releases all pins (R1)
    wr(2'd0, 8'h00);
    chk("R1 disabled pins released", {sck_oe, mosi_oe, miso_oe}, 3'b000);

    // Constrained random master traffic
    for (int t = 0; t < 24; t++) begin
      a = 8'($urandom);
      master_xfer(a, 2'($urandom % 3), 1'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), ($urandom % 5) == 0);
    end

    // Slave: deselected SCK noise first, then all four modes
    slave_xfer(8'h96, 8'h4B, 1'b0, 1'b0, 1'b0, 1'b1);
    slave_xfer(8'h0F, 8'hF0, 1'b1, 1'b1, 1'b1, 1'b1);
    for (int t = 0; t < 16; t++) begin
      slave_xfer(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), ($urandom % 4) == 0);
    end

    wr(2'd0, 8'h00);
    chk("R1 final release", {sck_oe, mosi_oe, miso_oe}, 3'b000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule